// File: doc/BRIEF.md
# Load/Store Address Translation and Fault Classifier

This block sits between a data pipeline and its translation buffer. For every load or store it takes the virtual address, the access width, the privilege state and the lookup result that the buffer returns for that address. One clock later it returns either a physical address with an uncacheable flag, or a fault kind with a status vector that says why the access was refused. The buffer array itself lives outside this block. Only its lookup result (hit, page number, per-mode read and write enable masks, and the two fault-on-access bits) enters here.

The effective privilege mode for permission checks depends on the low bit of the program counter. When that bit is set, the request runs at the alternate mode if it asks for it, and at kernel mode if it does not. The checks run in a fixed priority order: alignment, physical pass-through, address-form validity, the direct-mapped kernel window, buffer miss, and then permission and fault-on-access bits. The block also keeps six saturating event counters: hits, misses and violations, each kept separately for loads and stores.

Top module: `xlat_fault_unit`

## Requirements
- R1: An access whose address has any bit set in `va & (size-1)` (size is the byte count 1, 2, 4 or 8) gives fault kind 1 (align). Its status has only bit 0 (write) set, and only for stores. This check comes before every other check, including physical mode.
- R2: The effective mode is the current mode when `pc_lsb` is 0. When `pc_lsb` is 1, it is the alternate mode if `req_alt` is 1 and kernel (0) if not. Mode codes are kernel 0, exec 1, super 2, user 3, and a mode's code is its bit index in the enable masks.
- R3: In physical mode the PA is the low 44 VA bits. If any VA bit at 44 or above is set, the result is fault kind 6 (machine check) with a zero status. Physical accesses are never counted.
- R4: A non-physical VA whose bits 63:42 are not all equal gives fault kind 3 (page) with status bits 4 (bad VA) and 1 (access violation) set, plus bit 0 for stores.
- R5: A valid VA with bits 47:41 equal to 0x7e lies in the kernel window. If the current mode (not the effective mode) is not kernel, the result is fault kind 2 (acv) with bit 1 set, plus bit 0 for stores. Otherwise the PA is VA bits 39:0, with PA bits 43:40 all copies of VA bit 40.
- R6: A buffer miss sets status bit 5, plus bit 0 for stores. It gives fault kind 5 when `req_pte` is 1 and kind 4 when it is 0.
- R7: On a store hit whose write-enable bit for the effective mode is clear, the result is kind 3 with bits 0 and 1 set, plus bit 3 if fault-on-write is set. If the enable bit is set but fault-on-write is set, the result is kind 3 with bits 0 and 3 set.
- R8: On a load hit whose read-enable bit for the effective mode is clear, the result is kind 2 with bit 1 set, plus bit 2 if fault-on-read is set. If the enable bit is set but fault-on-read is set, the result is kind 3 with only bit 2 set.
- R9: A permitted buffer hit gives kind 0 with PA = {PPN, VA[12:0]}. The uncacheable flag equals PA bit 43 on every successful access. On any fault, both the PA and the flag are 0.
- R10: When a request completes, exactly one counter advances by one. The load counter is used for loads and the store counter for stores. A successful non-physical access counts as a hit, a miss counts as a miss, and a fault of kind 2 or 3 counts as a violation. Alignment faults, machine checks and idle cycles count nothing.
- R11: Each counter holds at its maximum value (all ones, CNT_W bits) instead of wrapping.
- R12: Results appear exactly one cycle after `req_valid`. After reset, `rsp_valid` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Virtual address |
| req_size | input | 4 | Access width in bytes (1, 2, 4, 8) |
| req_wr | input | 1 | 1 for a store |
| req_phys | input | 1 | Physical-mode request, no translation |
| req_alt | input | 1 | Use the alternate mode when `pc_lsb` is set |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| pc_lsb | input | 1 | Low bit of the program counter |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| tlb_hit | input | 1 | Buffer lookup hit |
| tlb_ppn | input | PA_W-PG_OFS | Physical page number from the buffer |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fon_rd | input | 1 | Fault-on-read bit |
| tlb_fon_wr | input | 1 | Fault-on-write bit |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | PA_W | Physical address (0 on fault) |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | Fault kind (0 none) |
| rsp_status | output | 6 | Status: 0 write, 1 acv, 2 fault-on-read, 3 fault-on-write, 4 bad VA, 5 miss |
| cnt_rd_hit | output | CNT_W | Load hits |
| cnt_wr_hit | output | CNT_W | Store hits |
| cnt_rd_miss | output | CNT_W | Load misses |
| cnt_wr_miss | output | CNT_W | Store misses |
| cnt_rd_acv | output | CNT_W | Load violations |
| cnt_wr_acv | output | CNT_W | Store violations |

## Verification
The hardest case to reach is an interaction among three inputs. An access with the PC low bit set and alternate selection off runs at kernel mode for permissions. The kernel-window check still uses the current mode, and a store's enable mask must never be confused with the load's. The bench sweeps every combination of PC bit, alternate flag, both modes, all sixteen enable masks and both fault-on bits for loads and stores. It drives the opposite mask with the complement, so that a swapped mask changes the outcome. The kernel-window cases use PC bit 1 with a user current mode, so a check that wrongly used the effective mode would pass the access. The counters are kept narrow, so the long sweep drives them into saturation after the early stages have checked their exact increments.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    FK_NONE   = 3'd0,
    FK_ALIGN  = 3'd1,
    FK_ACV    = 3'd2,
    FK_PAGE   = 3'd3,
    FK_MISS_N = 3'd4,
    FK_MISS_P = 3'd5,
    FK_MCHK   = 3'd6
  } fault_e;

  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_FONR  = 2;
  localparam int ST_FONW  = 3;
  localparam int ST_BADVA = 4;
  localparam int ST_MISS  = 5;
  localparam int ST_W     = 6;

  localparam logic [1:0] MODE_KERNEL = 2'd0;
  localparam int         N_MODES     = 4;

  localparam int         WIN_HI  = 47;
  localparam int         WIN_LO  = 41;
  localparam logic [6:0] WIN_TAG = 7'h7e;
  localparam int         WIN_EXT = 4;

  localparam int CI_RD_HIT  = 0;
  localparam int CI_WR_HIT  = 1;
  localparam int CI_RD_MISS = 2;
  localparam int CI_WR_MISS = 3;
  localparam int CI_RD_ACV  = 4;
  localparam int CI_WR_ACV  = 5;
  localparam int N_CNT      = 6;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel (
  input  logic       pc_lsb,
  input  logic       use_alt,
  input  logic [1:0] cur_mode,
  input  logic [1:0] alt_mode,
  output logic [1:0] eff_mode
);
  import xlat_pkg::*;

  always_comb begin
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end

endmodule

// File: rtl/xlat_classify.sv
module xlat_classify #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int PG_OFS  = 13
) (
  input  logic [VA_W-1:0]        va,
  input  logic [3:0]             size,
  input  logic                   is_wr,
  input  logic                   phys,
  input  logic                   pte_fetch,
  input  logic [1:0]             cur_mode,
  input  logic [1:0]             eff_mode,
  input  logic                   tlb_hit,
  input  logic [PA_W-PG_OFS-1:0] ppn,
  input  logic [3:0]             rd_en,
  input  logic [3:0]             wr_en,
  input  logic                   fon_rd,
  input  logic                   fon_wr,
  output xlat_pkg::fault_e       kind,
  output logic [5:0]             status,
  output logic [PA_W-1:0]        pa,
  output logic                   uncached,
  output logic                   ev_hit,
  output logic                   ev_miss,
  output logic                   ev_acv
);
  import xlat_pkg::*;

  localparam int SIGN_LO = VA_IMPL - 1;
  localparam int EXT_BIT = PA_W - WIN_EXT;

  logic misal, va_ok, in_win, rd_ok, wr_ok;

  always_comb begin
    misal  = |(va[3:0] & (size - 4'd1));
    va_ok  = (&va[VA_W-1:SIGN_LO]) | ~(|va[VA_W-1:SIGN_LO]);
    in_win = (va[WIN_HI:WIN_LO] == WIN_TAG);
    rd_ok  = rd_en[eff_mode];
    wr_ok  = wr_en[eff_mode];
  end

  always_comb begin
    kind    = FK_NONE;
    status  = '0;
    pa      = '0;
    ev_hit  = 1'b0;
    ev_miss = 1'b0;
    ev_acv  = 1'b0;
    if (misal) begin
      kind          = FK_ALIGN;
      status[ST_WR] = is_wr;
    end else if (phys) begin
      if (|va[VA_W-1:PA_W]) kind = FK_MCHK;
      else                  pa   = va[PA_W-1:0];
    end else if (!va_ok) begin
      kind             = FK_PAGE;
      status[ST_WR]    = is_wr;
      status[ST_ACV]   = 1'b1;
      status[ST_BADVA] = 1'b1;
      ev_acv           = 1'b1;
    end else if (in_win) begin
      if (cur_mode != MODE_KERNEL) begin
        kind           = FK_ACV;
        status[ST_WR]  = is_wr;
        status[ST_ACV] = 1'b1;
        ev_acv         = 1'b1;
      end else begin
        pa     = {{WIN_EXT{va[EXT_BIT]}}, va[EXT_BIT-1:0]};
        ev_hit = 1'b1;
      end
    end else if (!tlb_hit) begin
      kind            = pte_fetch ? FK_MISS_P : FK_MISS_N;
      status[ST_WR]   = is_wr;
      status[ST_MISS] = 1'b1;
      ev_miss         = 1'b1;
    end else if (is_wr) begin
      if (!wr_ok) begin
        kind            = FK_PAGE;
        status[ST_WR]   = 1'b1;
        status[ST_ACV]  = 1'b1;
        status[ST_FONW] = fon_wr;
        ev_acv          = 1'b1;
      end else if (fon_wr) begin
        kind            = FK_PAGE;
        status[ST_WR]   = 1'b1;
        status[ST_FONW] = 1'b1;
        ev_acv          = 1'b1;
      end else begin
        pa     = {ppn, va[PG_OFS-1:0]};
        ev_hit = 1'b1;
      end
    end else begin
      if (!rd_ok) begin
        kind            = FK_ACV;
        status[ST_ACV]  = 1'b1;
        status[ST_FONR] = fon_rd;
        ev_acv          = 1'b1;
      end else if (fon_rd) begin
        kind            = FK_PAGE;
        status[ST_FONR] = 1'b1;
        ev_acv          = 1'b1;
      end else begin
        pa     = {ppn, va[PG_OFS-1:0]};
        ev_hit = 1'b1;
      end
    end
    uncached = (kind == FK_NONE) && pa[PA_W-1];
  end

endmodule

// File: rtl/xlat_counters.sv
module xlat_counters #(
  parameter int N = 6,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)                          cnt[i] <= '0;
      else if (inc[i] && cnt[i] != CMAX) cnt[i] <= cnt[i] + 1'b1;
    end

    p_hold_max_r11: assert property (@(posedge clk) disable iff (rst)
      (cnt[i] == CMAX) |=> (cnt[i] == CMAX));

    p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
      !inc[i] |=> $stable(cnt[i]));
  end

endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int PG_OFS  = 13,
  parameter int CNT_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_va,
  input  logic [3:0]             req_size,
  input  logic                   req_wr,
  input  logic                   req_phys,
  input  logic                   req_alt,
  input  logic                   req_pte,
  input  logic                   pc_lsb,
  input  logic [1:0]             cur_mode,
  input  logic [1:0]             alt_mode,
  input  logic                   tlb_hit,
  input  logic [PA_W-PG_OFS-1:0] tlb_ppn,
  input  logic [3:0]             tlb_rd_en,
  input  logic [3:0]             tlb_wr_en,
  input  logic                   tlb_fon_rd,
  input  logic                   tlb_fon_wr,
  output logic                   rsp_valid,
  output logic [PA_W-1:0]        rsp_pa,
  output logic                   rsp_uncached,
  output logic [2:0]             rsp_fault,
  output logic [5:0]             rsp_status,
  output logic [CNT_W-1:0]       cnt_rd_hit,
  output logic [CNT_W-1:0]       cnt_wr_hit,
  output logic [CNT_W-1:0]       cnt_rd_miss,
  output logic [CNT_W-1:0]       cnt_wr_miss,
  output logic [CNT_W-1:0]       cnt_rd_acv,
  output logic [CNT_W-1:0]       cnt_wr_acv
);
  import xlat_pkg::*;

  logic [1:0]      eff_mode;
  fault_e          c_kind;
  logic [5:0]      c_status;
  logic [PA_W-1:0] c_pa;
  logic            c_unc, ev_hit, ev_miss, ev_acv;
  logic [N_CNT-1:0]            inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  xlat_mode_sel u_mode (
    .pc_lsb   (pc_lsb),
    .use_alt  (req_alt),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  xlat_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .PG_OFS(PG_OFS)
  ) u_cls (
    .va        (req_va),
    .size      (req_size),
    .is_wr     (req_wr),
    .phys      (req_phys),
    .pte_fetch (req_pte),
    .cur_mode  (cur_mode),
    .eff_mode  (eff_mode),
    .tlb_hit   (tlb_hit),
    .ppn       (tlb_ppn),
    .rd_en     (tlb_rd_en),
    .wr_en     (tlb_wr_en),
    .fon_rd    (tlb_fon_rd),
    .fon_wr    (tlb_fon_wr),
    .kind      (c_kind),
    .status    (c_status),
    .pa        (c_pa),
    .uncached  (c_unc),
    .ev_hit    (ev_hit),
    .ev_miss   (ev_miss),
    .ev_acv    (ev_acv)
  );

  always_comb begin
    inc             = '0;
    inc[CI_RD_HIT]  = req_valid & ev_hit  & ~req_wr;
    inc[CI_WR_HIT]  = req_valid & ev_hit  &  req_wr;
    inc[CI_RD_MISS] = req_valid & ev_miss & ~req_wr;
    inc[CI_WR_MISS] = req_valid & ev_miss &  req_wr;
    inc[CI_RD_ACV]  = req_valid & ev_acv  & ~req_wr;
    inc[CI_WR_ACV]  = req_valid & ev_acv  &  req_wr;
  end

  xlat_counters #(.N(N_CNT), .W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (inc),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= '0;
      rsp_status   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa       <= c_pa;
        rsp_uncached <= c_unc;
        rsp_fault    <= c_kind;
        rsp_status   <= c_status;
      end
    end
  end

  assign cnt_rd_hit  = cnt[CI_RD_HIT];
  assign cnt_wr_hit  = cnt[CI_WR_HIT];
  assign cnt_rd_miss = cnt[CI_RD_MISS];
  assign cnt_wr_miss = cnt[CI_WR_MISS];
  assign cnt_rd_acv  = cnt[CI_RD_ACV];
  assign cnt_wr_acv  = cnt[CI_WR_ACV];

  p_align_first_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && |(req_va[3:0] & (req_size - 4'd1)))
      |=> (rsp_fault == FK_ALIGN) && (rsp_status == {5'b0, $past(req_wr)}));

  p_one_cycle_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_miss_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault == FK_MISS_N || rsp_fault == FK_MISS_P))
      |-> (rsp_status[ST_MISS] && !rsp_status[ST_ACV]));

  p_fault_clears_pa_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FK_NONE) |-> (rsp_pa == '0 && !rsp_uncached));

  p_single_event_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(inc) <= 1);

endmodule

// File: tb/xlat_fault_unit_tb.sv
module xlat_fault_unit_tb;

  localparam int VA_W  = 64;
  localparam int PA_W  = 44;
  localparam int PG    = 13;
  localparam int PPN_W = PA_W - PG;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             req_valid = 0, req_wr = 0, req_phys = 0, req_alt = 0, req_pte = 0, pc_lsb = 0;
  logic [VA_W-1:0]  req_va = '0;
  logic [3:0]       req_size = 4'd8;
  logic [1:0]       cur_mode = 0, alt_mode = 0;
  logic             tlb_hit = 0, tlb_fon_rd = 0, tlb_fon_wr = 0;
  logic [PPN_W-1:0] tlb_ppn = '0;
  logic [3:0]       tlb_rd_en = 0, tlb_wr_en = 0;
  logic             rsp_valid, rsp_uncached;
  logic [PA_W-1:0]  rsp_pa;
  logic [2:0]       rsp_fault;
  logic [5:0]       rsp_status;
  logic [CNT_W-1:0] c_rh, c_wh, c_rm, c_wm, c_ra, c_wa;

  xlat_fault_unit #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va), .req_size(req_size),
    .req_wr(req_wr), .req_phys(req_phys), .req_alt(req_alt), .req_pte(req_pte),
    .pc_lsb(pc_lsb), .cur_mode(cur_mode), .alt_mode(alt_mode), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en),
    .tlb_fon_rd(tlb_fon_rd), .tlb_fon_wr(tlb_fon_wr), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
    .rsp_status(rsp_status), .cnt_rd_hit(c_rh), .cnt_wr_hit(c_wh),
    .cnt_rd_miss(c_rm), .cnt_wr_miss(c_wm), .cnt_rd_acv(c_ra), .cnt_wr_acv(c_wa)
  );

  int total = 0;
  int bad = 0;
  int ec[6];

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected result from the requirement text
  task automatic model(output int k, output int st, output longint pa, output int cls);
    logic [1:0] em;
    logic       w;
    w = req_wr; k = 0; st = 0; pa = 0; cls = 0;
    em = !pc_lsb ? cur_mode : (req_alt ? alt_mode : 2'd0);
    if ((req_va[3:0] & (req_size - 4'd1)) != 0) begin k = 1; st = w; end
    else if (req_phys) begin
      if (req_va[63:44] != 0) k = 6; else pa = longint'(req_va[43:0]);
    end else if (!(req_va[63:42] == '0 || req_va[63:42] == '1)) begin
      k = 3; st = 16 + 2 + w; cls = 3;
    end else if (req_va[47:41] == 7'h7e) begin
      if (cur_mode != 0) begin k = 2; st = 2 + w; cls = 3; end
      else begin
        pa = longint'(req_va[39:0]) + (req_va[40] ? 64'hF00_0000_0000 : 64'h0);
        cls = 1;
      end
    end else if (!tlb_hit) begin
      k = req_pte ? 5 : 4; st = 32 + w; cls = 2;
    end else if (w) begin
      if (!tlb_wr_en[em])  begin k = 3; st = 3 + (tlb_fon_wr ? 8 : 0); cls = 3; end
      else if (tlb_fon_wr) begin k = 3; st = 9; cls = 3; end
      else begin pa = longint'(tlb_ppn) * 8192 + longint'(req_va[12:0]); cls = 1; end
    end else begin
      if (!tlb_rd_en[em])  begin k = 2; st = 2 + (tlb_fon_rd ? 4 : 0); cls = 3; end
      else if (tlb_fon_rd) begin k = 3; st = 4; cls = 3; end
      else begin pa = longint'(tlb_ppn) * 8192 + longint'(req_va[12:0]); cls = 1; end
    end
  endtask

  task automatic bump(int idx);
    if (ec[idx] < CMAX) ec[idx]++;
  endtask

  task automatic step(string tag, string ctag);
    int k, st, cls;
    longint pa;
    model(k, st, pa, cls);
    if (req_valid && !(req_phys && k != 1 && k != 6 && cls == 0) && cls != 0)
      bump((cls == 1 ? 0 : cls == 2 ? 2 : 4) + (req_wr ? 1 : 0));
    @(negedge clk);
    if (req_valid) begin
      chk(tag, "valid", rsp_valid, 1);
      chk(tag, "fault", rsp_fault, k);
      chk(tag, "status", rsp_status, st);
      chk(tag, "pa", rsp_pa, pa);
      chk("R9", "uncached", rsp_uncached, (k == 0) ? ((pa >> 43) & 1) : 0);
    end else chk(tag, "valid", rsp_valid, 0);
    chk(ctag, "cnt_rd_hit", c_rh, ec[0]);
    chk(ctag, "cnt_wr_hit", c_wh, ec[1]);
    chk(ctag, "cnt_rd_miss", c_rm, ec[2]);
    chk(ctag, "cnt_wr_miss", c_wm, ec[3]);
    chk(ctag, "cnt_rd_acv", c_ra, ec[4]);
    chk(ctag, "cnt_wr_acv", c_wa, ec[5]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) ec[i] = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "rsp_valid after reset", rsp_valid, 0);
    chk("R12", "counters after reset", {c_rh, c_wh, c_rm, c_wm, c_ra, c_wa}, 0);
    rst = 1'b0;
    // R12: idle cycle with a miss pattern counts nothing
    req_valid = 0; tlb_hit = 0; req_va = 64'h1000;
    step("R12", "R10");
    req_valid = 1;

    // R1: alignment over every width and low offset, ahead of physical and bad VA
    for (int s = 0; s < 4; s++)
      for (int lo = 0; lo < 8; lo++)
        for (int w = 0; w < 2; w++) begin
          req_size = 4'(1 << s); req_wr = w[0]; req_phys = (lo % 2 == 0);
          req_va = req_phys ? 64'(32'h1234_5670 + lo) : (64'h8000_0000_0000_0000 + 64'(lo));
          step("R1", "R10");
        end
    req_size = 4'd8; req_phys = 1;

    // R3: physical pass-through and machine check
    req_va = 64'h0000_0ABC_DEF0_1238; req_wr = 0; step("R3", "R10");
    req_va = 64'h0000_0123_4567_8AB0; req_wr = 1; step("R3", "R10");
    req_va = 64'h0010_0000_0000_0000; req_wr = 0; step("R3", "R10");
    req_va = 64'h8000_0000_0000_0008; req_wr = 1; step("R3", "R10");
    req_phys = 0;

    // R4: malformed addresses
    for (int w = 0; w < 2; w++) begin
      req_wr = w[0];
      req_va = 64'h0000_0400_0000_0000; step("R4", "R10");
      req_va = 64'h8000_0000_0000_1000; step("R4", "R10");
      req_va = 64'hFFFF_F800_0000_0000; step("R4", "R10");
    end

    // R5: kernel window judged on current mode; PC bit makes effective mode kernel
    pc_lsb = 1; req_alt = 0; tlb_hit = 0;
    for (int cm = 0; cm < 4; cm++)
      for (int b40 = 0; b40 < 2; b40++)
        for (int w = 0; w < 2; w++) begin
          cur_mode = 2'(cm); req_wr = w[0];
          req_va = 64'hFFFF_FC00_0000_1238 | (64'(b40) << 40) | 64'h0000_0012_3400_0000;
          step("R5", "R10");
        end
    pc_lsb = 0; cur_mode = 0;

    // R6: misses with both fetch kinds
    req_va = 64'h0000_0000_0042_2000; tlb_hit = 0;
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < 2; w++) begin
        req_pte = p[0]; req_wr = w[0]; step("R6", "R10");
      end
    req_pte = 0;
    // R9: permitted hit with uncacheable page
    tlb_hit = 1; tlb_rd_en = 4'hF; tlb_wr_en = 4'hF; tlb_fon_rd = 0; tlb_fon_wr = 0;
    tlb_ppn = 31'h4000_1234; req_wr = 0; req_va = 64'h0000_0000_0042_3A58; step("R9", "R10");
    tlb_ppn = 31'h0000_0777; req_wr = 1; step("R9", "R10");

    // R2 R7 R8 R11: full permission sweep; counters reach saturation here
    for (int w = 0; w < 2; w++)
      for (int pl = 0; pl < 2; pl++)
        for (int as = 0; as < 2; as++)
          for (int cm = 0; cm < 4; cm++)
            for (int am = 0; am < 4; am++)
              for (int mk = 0; mk < 16; mk++)
                for (int fn = 0; fn < 4; fn++) begin
                  int idx;
                  idx = ((((w * 2 + pl) * 2 + as) * 4 + cm) * 4 + am) * 64 + mk * 4 + fn;
                  req_wr = w[0]; pc_lsb = pl[0]; req_alt = as[0];
                  cur_mode = 2'(cm); alt_mode = 2'(am);
                  tlb_rd_en = w ? ~4'(mk) : 4'(mk);
                  tlb_wr_en = w ? 4'(mk) : ~4'(mk);
                  tlb_fon_rd = fn[0]; tlb_fon_wr = fn[1];
                  tlb_ppn = PPN_W'(idx * 37 + 5);
                  req_va = {32'h0, 19'(idx), 13'(idx * 8)};
                  step(w ? "R7" : "R8", "R11");
                end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule